// File: doc/BRIEF.md
# Vectored Interrupt Collector with Fast-Request Steering

This block gathers a parameterised number of level-sensitive interrupt lines and turns them into two processor-facing signals: a normal interrupt request (`irq_o`) and a fast interrupt request (`fiq_o`). Each source has its own control word with four fields: an enable, a steering bit that moves the source to the fast path, a software force bit that raises the request without the hardware line, and a priority level. Sources on the normal path are arbitrated. The winner is latched in a holding register, and a state machine drives the normal request from that register.

Firmware services a normal interrupt in three steps. It reads the vector register, which returns a base address plus four times the held source number. That read is also the in-service notification, so the normal request drops at the same clock edge that returns the data. The handler then runs. Finally firmware writes the serviced priority level to the level-acknowledge register, which puts the state machine back at its base level, ready for the next capture. A status register can also be read as a pure flush read; reading it has no side effect. The fast path is not latched: it follows the enabled, steered requests one register stage later.

Top module: `irq_collector`

## Requirements
- R1: After reset every control word is zero, `irq_o` and `fiq_o` are low, and the status register reads 0 (state field 0 = base level).
- R2: The control word of source n sits at address 2^(ADDR_W-1)+n and reads back what was written: bit 0 enable, bit 1 fast-path steering, bit 2 software force, bits [3 +: PRIO_W] priority. Addresses in that region with no source read 0.
- R3: A source requests when its enable bit is set and either its line or its software force bit is high. A disabled source never raises any output.
- R4: `fiq_o` is high one cycle after some enabled, steered source requests, and low one cycle after none does. It is never latched.
- R5: A steered source never takes part in normal arbitration, never enters the holding register, and never raises `irq_o`.
- R6: Among requesting unsteered sources, the highest priority level wins. Equal levels go to the lower source number.
- R7: At base level, a winner is captured at one edge and `irq_o` is high after that edge. The held source and `irq_o` stay put even if the request is removed, until the vector read.
- R8: A read of address 1 returns vector base + 4·(held source) one cycle later. When the state is pending, the same edge drops `irq_o` and enters the in-service state (state field 2).
- R9: In service, a write to address 2 whose bits [PRIO_W-1:0] equal the held priority returns the state to base (0). Any other value is ignored.
- R10: A read of address 0 returns the state in bits [1:0] (0 base, 1 pending, 2 in service), the held priority in bits [7:4] and the held source number in bits [15:8]. The read changes nothing.
- R11: Address 3 holds the vector base. It resets to VBASE_RST, can be written, and reads back.
- R12: A vector read outside the pending state returns the current held vector and leaves the state and `irq_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | NUM_SRC | Level-sensitive request lines |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid one cycle after the read strobe |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with six sources, two priority bits and a four-bit address. That makes the source region only eight words deep, so unpopulated slots at indices 6 and 7 can be read, and a source count that is not a power of two is covered. With four priority levels and six sources, a tie between two equal levels, a win by a higher level over a lower number, and a steered source holding the top level while losing the normal path can all be set up in a few writes. Several vector-base values show that the vector arithmetic does not depend on the reset base.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    ST_BASE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_INSVC = 2'd2
  } irqc_state_e;

  // control word field positions
  localparam int CTL_EN   = 0;
  localparam int CTL_FIQ  = 1;
  localparam int CTL_SOFT = 2;
  localparam int CTL_PRIO = 3;

  // fixed register addresses below the source region
  localparam int REG_STATUS = 0;
  localparam int REG_VECTOR = 1;
  localparam int REG_LVLACK = 2;
  localparam int REG_VBASE  = 3;
endpackage

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 2,
  parameter int ADDR_W  = 6,
  localparam int CTL_W  = 3 + PRIO_W,
  localparam int IDX_W  = ADDR_W - 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [CTL_W-1:0]            wdata_i,
  input  logic [NUM_SRC-1:0]          src_i,
  output logic [NUM_SRC*CTL_W-1:0]    ctl_flat_o,
  output logic [NUM_SRC*PRIO_W-1:0]   prio_flat_o,
  output logic [NUM_SRC-1:0]          elig_o,
  output logic                        fiq_o
);
  logic [NUM_SRC-1:0] fiq_req;
  logic [NUM_SRC-1:0] en_mask;
  logic               fiq_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [CTL_W-1:0] ctl_q;
    logic             req;

    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q <= '0;
      end else if (wr_en_i && addr_i[ADDR_W-1] && (addr_i[IDX_W-1:0] == IDX_W'(g))) begin
        ctl_q <= wdata_i;
      end
    end

    assign req        = (src_i[g] | ctl_q[CTL_SOFT]) & ctl_q[CTL_EN];
    assign elig_o[g]  = req & ~ctl_q[CTL_FIQ];
    assign fiq_req[g] = req &  ctl_q[CTL_FIQ];
    assign en_mask[g] = ctl_q[CTL_EN] & ctl_q[CTL_FIQ];
    assign ctl_flat_o[g*CTL_W +: CTL_W]    = ctl_q;
    assign prio_flat_o[g*PRIO_W +: PRIO_W] = ctl_q[CTL_PRIO +: PRIO_W];
  end

  always_ff @(posedge clk) begin
    if (rst) fiq_q <= 1'b0;
    else     fiq_q <= |fiq_req;
  end

  assign fiq_o = fiq_q;

  // R4
  fiq_needs_enabled_steer_chk: assert property (@(posedge clk) disable iff (rst)
    fiq_q |-> $past(|en_mask));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 2,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]        elig_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat_i,
  output logic                      any_o,
  output logic [ID_W-1:0]           win_id_o,
  output logic [PRIO_W-1:0]         win_prio_o
);
  // scan from the top index downward; ">=" hands ties to the lower number
  always_comb begin
    any_o      = 1'b0;
    win_id_o   = '0;
    win_prio_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig_i[i] && (!any_o || (prio_flat_i[i*PRIO_W +: PRIO_W] >= win_prio_o))) begin
        any_o      = 1'b1;
        win_id_o   = ID_W'(i);
        win_prio_o = prio_flat_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irqc_fsm.sv
module irqc_fsm
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 2,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] elig_i,
  input  logic               any_i,
  input  logic [ID_W-1:0]    win_id_i,
  input  logic [PRIO_W-1:0]  win_prio_i,
  input  logic               vec_rd_i,
  input  logic               ack_wr_i,
  input  logic [PRIO_W-1:0]  ack_lvl_i,
  output logic [1:0]         state_o,
  output logic [ID_W-1:0]    hold_id_o,
  output logic [PRIO_W-1:0]  hold_prio_o,
  output logic               irq_o
);
  irqc_state_e       state_q, state_n;
  logic [ID_W-1:0]   hold_id_q;
  logic [PRIO_W-1:0] hold_prio_q;
  logic              irq_q;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_BASE:  if (any_i) state_n = ST_PEND;
      ST_PEND:  if (vec_rd_i) state_n = ST_INSVC;
      ST_INSVC: if (ack_wr_i && (ack_lvl_i == hold_prio_q)) state_n = ST_BASE;
      default:  state_n = ST_BASE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_BASE;
      irq_q       <= 1'b0;
      hold_id_q   <= '0;
      hold_prio_q <= '0;
    end else begin
      state_q <= state_n;
      irq_q   <= (state_n == ST_PEND);
      if (state_q == ST_BASE && any_i) begin
        hold_id_q   <= win_id_i;
        hold_prio_q <= win_prio_i;
      end
    end
  end

  assign state_o     = state_q;
  assign hold_id_o   = hold_id_q;
  assign hold_prio_o = hold_prio_q;
  assign irq_o       = irq_q;

  // R5
  capture_only_eligible_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(elig_i[win_id_i]));

  // R7
  hold_frozen_outside_base_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_BASE) |=> $stable(hold_id_q) && $stable(hold_prio_q));

  // R8
  vector_read_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PEND && vec_rd_i) |=> !irq_q && (state_q == ST_INSVC));

  // R9
  mismatched_ack_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_INSVC && !(ack_wr_i && ack_lvl_i == hold_prio_q)) |=> (state_q == ST_INSVC));

  // R9
  matched_ack_to_base_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_INSVC && ack_wr_i && ack_lvl_i == hold_prio_q) |=> (state_q == ST_BASE) && !irq_q);
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irqc_pkg::*;
#(
  parameter int          NUM_SRC   = 16,
  parameter int          PRIO_W    = 2,
  parameter int          ADDR_W    = 6,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] VBASE_RST = 32'h0000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int ID_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CTL_W = 3 + PRIO_W;
  localparam int IDX_W = ADDR_W - 1;

  logic [NUM_SRC*CTL_W-1:0]  ctl_flat;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SRC-1:0]        elig;
  logic                      any;
  logic [ID_W-1:0]           win_id, hold_id;
  logic [PRIO_W-1:0]         win_prio, hold_prio;
  logic [1:0]                state;
  logic                      vec_rd, ack_wr, vbase_wr;
  logic [DATA_W-1:0]         vbase_q, vector, rd_val, rdata_q;

  assign vec_rd   = rd_en_i && (addr_i == ADDR_W'(REG_VECTOR));
  assign ack_wr   = wr_en_i && (addr_i == ADDR_W'(REG_LVLACK));
  assign vbase_wr = wr_en_i && (addr_i == ADDR_W'(REG_VBASE));

  irqc_ctrl_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i[CTL_W-1:0]),
    .src_i       (irq_src_i),
    .ctl_flat_o  (ctl_flat),
    .prio_flat_o (prio_flat),
    .elig_o      (elig),
    .fiq_o       (fiq_o)
  );

  irqc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .elig_i      (elig),
    .prio_flat_i (prio_flat),
    .any_o       (any),
    .win_id_o    (win_id),
    .win_prio_o  (win_prio)
  );

  irqc_fsm #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .elig_i      (elig),
    .any_i       (any),
    .win_id_i    (win_id),
    .win_prio_i  (win_prio),
    .vec_rd_i    (vec_rd),
    .ack_wr_i    (ack_wr),
    .ack_lvl_i   (wdata_i[PRIO_W-1:0]),
    .state_o     (state),
    .hold_id_o   (hold_id),
    .hold_prio_o (hold_prio),
    .irq_o       (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)           vbase_q <= DATA_W'(VBASE_RST);
    else if (vbase_wr) vbase_q <= wdata_i;
  end

  assign vector = vbase_q + (DATA_W'(hold_id) << 2);

  always_comb begin
    rd_val = '0;
    if (addr_i[ADDR_W-1]) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (addr_i[IDX_W-1:0] == IDX_W'(i)) rd_val = DATA_W'(ctl_flat[i*CTL_W +: CTL_W]);
      end
    end else begin
      unique case (addr_i)
        ADDR_W'(REG_STATUS): rd_val = DATA_W'(state) | (DATA_W'(hold_prio) << 4) | (DATA_W'(hold_id) << 8);
        ADDR_W'(REG_VECTOR): rd_val = vector;
        ADDR_W'(REG_VBASE):  rd_val = vbase_q;
        default:             rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !irq_o && !fiq_o && (state == 2'd0));

  // R12
  stray_vector_read_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && state == 2'd0 && !any) |=> !irq_o && (state == 2'd0));
endmodule

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
  localparam int N  = 6;
  localparam int PW = 2;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [31:0] VB = 32'h0000_0200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq, fiq;

  always #10 clk = ~clk;

  irq_collector #(.NUM_SRC(N), .PRIO_W(PW), .ADDR_W(AW), .DATA_W(DW), .VBASE_RST(VB)) u_irq_collector (
    .clk(clk), .rst(rst), .irq_src_i(src), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit    done = 0;

  // behavioural reference model
  int          m_en[N], m_st[N], m_sf[N], m_pr[N];
  int          m_state, m_hid, m_hpr;
  bit          m_irq, m_fiq, m_rdv;
  logic [31:0] m_vb, m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_en[i]) begin m_en[i] = 0; m_st[i] = 0; m_sf[i] = 0; m_pr[i] = 0; end
      m_state = 0; m_hid = 0; m_hpr = 0; m_irq = 0; m_fiq = 0; m_rdv = 0;
      m_vb = VB; m_rdata = 0;
    end else begin
      int best_id, best_pr;
      bit fnext;
      best_id = -1; best_pr = -1; fnext = 0;
      for (int i = 0; i < N; i++) begin
        bit r;
        r = (m_en[i] != 0) && (src[i] || m_sf[i] != 0);
        if (r && m_st[i] != 0) fnext = 1;
        if (r && m_st[i] == 0 && m_pr[i] > best_pr) begin best_pr = m_pr[i]; best_id = i; end
      end
      m_rdv = rd;
      if (rd) begin
        int a;
        a = addr;
        if (a == 0)      m_rdata = m_state + (m_hpr * 16) + (m_hid * 256);
        else if (a == 1) m_rdata = m_vb + 4 * m_hid;
        else if (a == 3) m_rdata = m_vb;
        else if (a >= 8 && a - 8 < N)
          m_rdata = m_en[a-8] + 2 * m_st[a-8] + 4 * m_sf[a-8] + 8 * m_pr[a-8];
        else m_rdata = 0;
      end
      if (m_state == 0 && best_id >= 0) begin
        m_state = 1; m_hid = best_id; m_hpr = best_pr;
      end else if (m_state == 1 && rd && addr == 1) begin
        m_state = 2;
      end else if (m_state == 2 && wr && addr == 2 && int'(wdata[1:0]) == m_hpr) begin
        m_state = 0;
      end
      m_irq = (m_state == 1);
      m_fiq = fnext;
      if (wr) begin
        int a;
        a = addr;
        if (a == 3) m_vb = wdata;
        else if (a >= 8 && a - 8 < N) begin
          m_en[a-8] = wdata[0]; m_st[a-8] = wdata[1]; m_sf[a-8] = wdata[2]; m_pr[a-8] = wdata[4:3];
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_cmp++;
      if (irq !== m_irq || fiq !== m_fiq) begin
        n_bad++;
        $display("FAIL %s model irq/fiq act=%0b%0b exp=%0b%0b", tag, irq, fiq, m_irq, m_fiq);
      end
      if (m_rdv) begin
        n_cmp++;
        if (rdata !== m_rdata) begin
          n_bad++;
          $display("FAIL %s model rdata act=%h exp=%h", tag, rdata, m_rdata);
        end
      end
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(int a, logic [31:0] d);
    @(negedge clk); wr = 1; addr = AW'(a); wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(int a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = AW'(a);
    @(negedge clk); rd = 0; d = rdata;
  endtask

  function automatic logic [31:0] ctl(int en, int st, int sf, int pr);
    return 32'(en + 2 * st + 4 * sf + 8 * pr);
  endfunction

  initial begin
    repeat (500) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired in %s", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    tag = "R1";
    rd_reg(0, d); chk("R1 status", d, 0);
    chk("R1 irq", 32'(irq), 0); chk("R1 fiq", 32'(fiq), 0);

    tag = "R11";
    rd_reg(3, d); chk("R11 base reset", d, VB);

    tag = "R2";
    wr_reg(8 + 2, ctl(1, 0, 0, 3));
    rd_reg(8 + 2, d); chk("R2 readback", d, 32'h19);
    wr_reg(8 + 7, 32'h1f);
    rd_reg(8 + 7, d); chk("R2 empty slot", d, 0);

    tag = "R3";
    src = 6'b000001; idle(3);
    chk("R3 disabled line", 32'(irq), 0);
    src = 0;
    wr_reg(8 + 2, ctl(1, 0, 1, 3)); idle(1);
    chk("R3 soft force", 32'(irq), 1);

    tag = "R10";
    rd_reg(0, d); chk("R10 status pend", d, 32'h231);
    chk("R10 no side effect", 32'(irq), 1);

    tag = "R8";
    rd_reg(1, d); chk("R8 vector", d, VB + 8);
    chk("R8 irq dropped", 32'(irq), 0);

    tag = "R9";
    wr_reg(8 + 2, ctl(1, 0, 0, 3));
    wr_reg(2, 1);
    rd_reg(0, d); chk("R9 mismatch ignored", d, 32'h232);
    wr_reg(2, 3);
    rd_reg(0, d); chk("R9 match to base", d, 32'h230);

    tag = "R12";
    rd_reg(1, d); chk("R12 vector in base", d, VB + 8);
    chk("R12 irq", 32'(irq), 0);
    rd_reg(0, d); chk("R12 state", d, 32'h230);

    tag = "R4";
    wr_reg(8 + 1, ctl(1, 1, 0, 3));
    src = 6'b000010; idle(2);
    chk("R4 fiq high", 32'(fiq), 1); chk("R4 no irq", 32'(irq), 0);
    src = 0; idle(2);
    chk("R4 fiq follows", 32'(fiq), 0);

    tag = "R5";
    wr_reg(8 + 3, ctl(1, 0, 0, 1));
    src = 6'b001010; idle(3);
    rd_reg(1, d); chk("R5 steered skipped", d, VB + 12);
    src = 0; wr_reg(2, 1); idle(1);

    tag = "R6";
    wr_reg(8 + 4, ctl(1, 0, 0, 2));
    wr_reg(8 + 5, ctl(1, 0, 0, 2));
    src = 6'b110000; idle(3);
    rd_reg(1, d); chk("R6 tie lower id", d, VB + 16);
    src = 0; wr_reg(2, 2); idle(1);
    src = 6'b101000; idle(3);
    rd_reg(1, d); chk("R6 higher level wins", d, VB + 20);
    src = 0; wr_reg(2, 2); idle(1);

    tag = "R7";
    src = 6'b100000; idle(2);
    src = 0; idle(3);
    chk("R7 irq held", 32'(irq), 1);
    rd_reg(1, d); chk("R7 held vector", d, VB + 20);
    wr_reg(2, 2); idle(2);

    tag = "R11";
    wr_reg(3, 32'h0000_4000);
    rd_reg(3, d); chk("R11 base readback", d, 32'h4000);
    src = 6'b001000; idle(3);
    rd_reg(1, d); chk("R11 new base vector", d, 32'h400c);
    src = 0; wr_reg(2, 1); idle(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule